// File: doc/BRIEF.md
# CPU Clock Mode and Source Sequencer

This block decides where a processor clock comes from and at what ratio it runs. It holds a PLL multiplier, a divide-select bit and a PLL power-down request, and it turns them into a PLL enable, a multiplier value for an external PLL model, a select that chooses between the raw input clock and the PLL output, and a ratio code. The ratio code is the output frequency expressed in half-steps of the input clock. There are three modes: off (PLL powered down), bypass (PLL powered but unused) and PLL (PLL output in use).

Each write to the multiplier drops the clock back to the input source at once. A lock wait then runs, and the PLL output is used only after lock. Lock comes either from an internal count of reference cycles or from an external lock input, chosen by a control bit. The PLL may be powered down only once the multiplier is zero. A power-down request made with a non-zero multiplier is refused and raises a sticky error flag.

Software reaches the block through a single synchronous register port with a write strobe, an address and data. Reads are combinational from the address.

Top module: `cpu_clk_mode_ctrl`

## Requirements
- R1: After reset, `mode`=1 (bypass), `pll_en`=1, `clk_sel`=0, `pll_mult`=0, `clk_ratio`=1, `err_flag`=0, and the lock-count register (address 2) reads the `RST_LOCK` parameter value.
- R2: In bypass and off modes, `clk_ratio` is 1 (input/2) when control bit 0 (address 1) is 0, and 2 (undivided input) when it is 1.
- R3: A write of a non-zero value n to address 0, outside off mode, sets `pll_mult`=n, `mode`=1 and `clk_sel`=0 from the next cycle. With counted lock (control bit 2 = 0) and lock count L (address 2), `clk_sel` becomes 1, `mode` becomes 2 and `clk_ratio` becomes n exactly L+1 clock edges after the write edge.
- R4: With external lock (control bit 2 = 1), the switch to the PLL happens at the first edge after the write edge at which `lock_in` is sampled high. A high `lock_in` has no effect when no lock wait is pending.
- R5: A multiplier write during a pending lock wait restarts the wait, so the L+1 count runs from the latest write.
- R6: Writing 0 to address 0 returns to bypass and cancels any pending wait, so `clk_sel` stays 0.
- R7: Writing control bit 1 = 1 while `pll_mult` is 0 enters off mode: `mode`=0, `pll_en`=0, `clk_sel`=0. Writing control bit 1 = 0 while in off mode returns to bypass with `pll_en`=1.
- R8: Writing control bit 1 = 1 while `pll_mult` is non-zero leaves the mode and `pll_en` unchanged and sets `err_flag`. The flag holds until a write to address 3 with bit 1 set.
- R9: In off mode, a non-zero write to address 0 is ignored (`pll_mult` stays 0 and the mode stays off) and sets `err_flag`.
- R10: Reads return the following:
  - address 0: the multiplier;
  - address 1: the divide bit in bit 0, off mode in bit 1 and the lock source in bit 2;
  - address 2: the lock count;
  - address 3: lock pending in bit 0, the error flag in bit 1 and the mode in bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset (power-up or external) |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| lock_in | input | 1 | External PLL lock indication |
| pll_en | output | 1 | PLL power enable |
| pll_mult | output | MULT_W | Multiplier value for the PLL |
| clk_sel | output | 1 | 1 selects PLL output, 0 selects input clock |
| clk_ratio | output | MULT_W | Output frequency in half-steps of the input clock |
| mode | output | 2 | 0 off, 1 bypass, 2 PLL |
| err_flag | output | 1 | Sticky illegal-request flag |

## Verification
A corrupted mode register shows up on `pll_en`, `clk_sel` and `clk_ratio` in the cycle right after the edge that corrupted it, so each check samples these ports one cycle after each write. A lock counter that loads wrongly, fails to restart or fails to clear moves the rising edge of `clk_sel` away from exactly L+1 edges after the last write. The bench samples both sides of that edge, so an early or late lock is caught. Faults in the error flag or in the off-mode guard appear as a wrong `err_flag`, `mode` or `pll_en` one cycle after the refused request, and again when status is read back at address 3.

// File: rtl/clkc_pkg.sv
package clkc_pkg;
   typedef enum logic [1:0] {
      MODE_OFF = 2'd0,
      MODE_BYP = 2'd1,
      MODE_PLL = 2'd2
   } clk_mode_e;

   localparam int unsigned REG_MULT = 0;
   localparam int unsigned REG_CTRL = 1;
   localparam int unsigned REG_LOCK = 2;
   localparam int unsigned REG_STAT = 3;

   localparam int unsigned CTRL_DIV_BIT  = 0;
   localparam int unsigned CTRL_OFF_BIT  = 1;
   localparam int unsigned CTRL_SRC_BIT  = 2;
   localparam int unsigned STAT_BUSY_BIT = 0;
   localparam int unsigned STAT_ERR_BIT  = 1;
   localparam int unsigned STAT_MODE_LSB = 2;
endpackage

// File: rtl/clkc_regfile.sv
module clkc_regfile
   import clkc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned MULT_W       = 4,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned RST_LOCK     = 100,
   parameter bit          HAS_EXT_LOCK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              div_sel,
   output logic              lock_src,
   output logic [CNT_W-1:0]  lock_cycles,
   output logic              mult_wr,
   output logic [MULT_W-1:0] mult_val,
   output logic              off_set_req,
   output logic              off_clr_req,
   output logic              err_clr
);
   logic hit_mult, hit_ctrl, hit_lock, hit_stat;

   always_comb begin
      hit_mult = wr_en && (addr == ADDR_W'(REG_MULT));
      hit_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
      hit_lock = wr_en && (addr == ADDR_W'(REG_LOCK));
      hit_stat = wr_en && (addr == ADDR_W'(REG_STAT));
   end

   assign mult_wr     = hit_mult;
   assign mult_val    = wdata[MULT_W-1:0];
   assign off_set_req = hit_ctrl &&  wdata[CTRL_OFF_BIT];
   assign off_clr_req = hit_ctrl && !wdata[CTRL_OFF_BIT];
   assign err_clr     = hit_stat &&  wdata[STAT_ERR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_sel     <= 1'b0;
         lock_cycles <= CNT_W'(RST_LOCK);
      end else begin
         if (hit_ctrl) div_sel     <= wdata[CTRL_DIV_BIT];
         if (hit_lock) lock_cycles <= wdata[CNT_W-1:0];
      end
   end

   generate
      if (HAS_EXT_LOCK) begin : g_src_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        lock_src <= 1'b0;
            else if (hit_ctrl) lock_src <= wdata[CTRL_SRC_BIT];
         end
      end else begin : g_src_tied
         assign lock_src = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/clkc_lock_timer.sv
module clkc_lock_timer #(
   parameter int unsigned CNT_W        = 16,
   parameter bit          HAS_EXT_LOCK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cancel,
   input  logic [CNT_W-1:0] lock_cycles,
   input  logic             use_ext,
   input  logic             lock_in,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             hit;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   generate
      if (HAS_EXT_LOCK) begin : g_ext
         assign hit = use_ext ? lock_in : cnt_zero;
      end else begin : g_cnt_only
         assign hit = cnt_zero;
      end
   endgenerate

   assign busy = pend_q;
   assign done = pend_q && !start && !cancel && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         pend_q <= 1'b1;
         cnt_q  <= lock_cycles;
      end else if (cancel) begin
         pend_q <= 1'b0;
      end else if (pend_q) begin
         if (hit)           pend_q <= 1'b0;
         else if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/clkc_mode_fsm.sv
module clkc_mode_fsm
   import clkc_pkg::*;
#(
   parameter int unsigned MULT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mult_wr,
   input  logic [MULT_W-1:0] mult_val,
   input  logic              off_set_req,
   input  logic              off_clr_req,
   input  logic              err_clr,
   input  logic              lock_done,
   output clk_mode_e         mode_q,
   output logic [MULT_W-1:0] mult_q,
   output logic              err_q,
   output logic              lock_start,
   output logic              lock_cancel
);
   logic accept;
   logic mult_nz;
   logic refuse_off;
   logic refuse_mult;

   always_comb begin
      mult_nz     = |mult_val;
      accept      = mult_wr && (mode_q != MODE_OFF);
      lock_start  = accept && mult_nz;
      lock_cancel = accept && !mult_nz;
      refuse_off  = off_set_req && (mult_q != '0);
      refuse_mult = mult_wr && (mode_q == MODE_OFF) && mult_nz;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_BYP;
         mult_q <= '0;
      end else if (accept) begin
         mult_q <= mult_val;
         mode_q <= MODE_BYP;
      end else if (off_set_req && !refuse_off) begin
         mode_q <= MODE_OFF;
      end else if (off_clr_req && (mode_q == MODE_OFF)) begin
         mode_q <= MODE_BYP;
      end else if (lock_done) begin
         mode_q <= MODE_PLL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      err_q <= 1'b0;
      else if (refuse_off || refuse_mult) err_q <= 1'b1;
      else if (err_clr)                err_q <= 1'b0;
   end
endmodule

// File: rtl/cpu_clk_mode_ctrl.sv
module cpu_clk_mode_ctrl
   import clkc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned MULT_W       = 4,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned RST_LOCK     = 100,
   parameter bit          HAS_EXT_LOCK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              lock_in,
   output logic              pll_en,
   output logic [MULT_W-1:0] pll_mult,
   output logic              clk_sel,
   output logic [MULT_W-1:0] clk_ratio,
   output logic [1:0]        mode,
   output logic              err_flag
);
   localparam int unsigned STAT_W = STAT_MODE_LSB + 2;

   generate
      if (MULT_W < 2)      begin : g_bad_mult $error("MULT_W must be at least 2"); end
      if (ADDR_W < 2)      begin : g_bad_addr $error("ADDR_W must be at least 2"); end
      if (DATA_W < MULT_W) begin : g_bad_dm   $error("DATA_W must cover MULT_W"); end
      if (DATA_W < CNT_W)  begin : g_bad_dc   $error("DATA_W must cover CNT_W"); end
      if (DATA_W < STAT_W) begin : g_bad_ds   $error("DATA_W must cover status"); end
      if (RST_LOCK >= (64'd1 << CNT_W)) begin : g_bad_rl $error("RST_LOCK exceeds CNT_W"); end
   endgenerate

   logic              div_sel, lock_src;
   logic [CNT_W-1:0]  lock_cycles;
   logic              mult_wr, off_set_req, off_clr_req, err_clr;
   logic [MULT_W-1:0] mult_val, mult_q;
   logic              lock_start, lock_cancel, lock_done, lock_busy;
   logic              err_q;
   clk_mode_e         mode_q;

   clkc_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MULT_W(MULT_W), .CNT_W(CNT_W),
      .RST_LOCK(RST_LOCK), .HAS_EXT_LOCK(HAS_EXT_LOCK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .div_sel(div_sel), .lock_src(lock_src), .lock_cycles(lock_cycles),
      .mult_wr(mult_wr), .mult_val(mult_val), .off_set_req(off_set_req),
      .off_clr_req(off_clr_req), .err_clr(err_clr)
   );

   clkc_lock_timer #(.CNT_W(CNT_W), .HAS_EXT_LOCK(HAS_EXT_LOCK)) u_lock (
      .clk(clk), .rst_n(rst_n), .start(lock_start), .cancel(lock_cancel),
      .lock_cycles(lock_cycles), .use_ext(lock_src), .lock_in(lock_in),
      .busy(lock_busy), .done(lock_done)
   );

   clkc_mode_fsm #(.MULT_W(MULT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .mult_wr(mult_wr), .mult_val(mult_val),
      .off_set_req(off_set_req), .off_clr_req(off_clr_req), .err_clr(err_clr),
      .lock_done(lock_done), .mode_q(mode_q), .mult_q(mult_q), .err_q(err_q),
      .lock_start(lock_start), .lock_cancel(lock_cancel)
   );

   assign pll_en    = (mode_q != MODE_OFF);
   assign clk_sel   = (mode_q == MODE_PLL);
   assign pll_mult  = mult_q;
   assign mode      = mode_q;
   assign err_flag  = err_q;
   assign clk_ratio = (mode_q == MODE_PLL) ? mult_q
                    : (div_sel ? MULT_W'(2) : MULT_W'(1));

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADDR_W'(REG_MULT): rdata[MULT_W-1:0] = mult_q;
         ADDR_W'(REG_CTRL): begin
            rdata[CTRL_DIV_BIT] = div_sel;
            rdata[CTRL_OFF_BIT] = (mode_q == MODE_OFF);
            rdata[CTRL_SRC_BIT] = lock_src;
         end
         ADDR_W'(REG_LOCK): rdata[CNT_W-1:0] = lock_cycles;
         ADDR_W'(REG_STAT): begin
            rdata[STAT_BUSY_BIT] = lock_busy;
            rdata[STAT_ERR_BIT]  = err_q;
            rdata[STAT_MODE_LSB +: 2] = mode_q;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/clkc_checker.sv
module clkc_checker #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned MULT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              pll_en,
   input logic [MULT_W-1:0] pll_mult,
   input logic              clk_sel,
   input logic [1:0]        mode,
   input logic              err_flag
);
   logic mult_hit;
   logic err_clr_hit;
   assign mult_hit    = wr_en && (addr == ADDR_W'(0));
   assign err_clr_hit = wr_en && (addr == ADDR_W'(3)) && wdata[1];

   // R3: an accepted multiplier write drops to the input clock next cycle
   assert_mult_write_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mult_hit && mode != 2'd0) |=> (!clk_sel && pll_mult == $past(wdata[MULT_W-1:0])));

   // R3: the PLL output is never selected with a zero multiplier
   assert_sel_needs_mult_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel |-> (pll_mult != '0));

   // R5: the select never rises on the edge right after a multiplier write
   assert_no_rise_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mult_hit && mode != 2'd0) |=> !clk_sel);

   // R8: off mode is unreachable in one step from a non-zero multiplier
   assert_off_needs_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0 && pll_mult != '0) |=> (mode != 2'd0));

   // R8: the error flag only clears by an explicit clear write
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr_hit) |=> err_flag);

   // R9: while off the multiplier stays zero
   assert_off_mult_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |=> (pll_mult == '0));

   // R7: leaving off mode only lands in bypass, and power returns with it
   assert_off_exit_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && pll_en == 1'b0) |=> (mode == 2'd0 || (mode == 2'd1 && pll_en)));
endmodule

bind cpu_clk_mode_ctrl clkc_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MULT_W(MULT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .pll_en(pll_en), .pll_mult(pll_mult), .clk_sel(clk_sel), .mode(mode),
   .err_flag(err_flag)
);

// File: tb/sim_cpu_clk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_clk_mode_ctrl;
   localparam int AW = 2;
   localparam int DW = 16;
   localparam int MW = 4;
   localparam int RL = 100;
   localparam int L  = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          lock_in = 1'b0;
   logic          pll_en, clk_sel, err_flag;
   logic [MW-1:0] pll_mult, clk_ratio;
   logic [1:0]    mode;

   always #2 clk = ~clk;

   cpu_clk_mode_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MULT_W(MW), .RST_LOCK(RL)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .lock_in(lock_in), .pll_en(pll_en), .pll_mult(pll_mult),
      .clk_sel(clk_sel), .clk_ratio(clk_ratio), .mode(mode), .err_flag(err_flag)
   );

   typedef struct {
      string         tag;
      bit            is_rd;
      logic [DW-1:0] rd;
      logic [1:0]    md;
      logic          en, sel, err;
      logic [MW-1:0] mult, ratio;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   // monitor: compare queued expectations against the ports at the falling edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (e.is_rd) begin
            if (rdata !== e.rd) begin
               n_fail++;
               $display("FAIL %s rdata actual=%h expected=%h", e.tag, rdata, e.rd);
            end
         end else if (mode !== e.md || pll_en !== e.en || clk_sel !== e.sel ||
                      err_flag !== e.err || pll_mult !== e.mult || clk_ratio !== e.ratio) begin
            n_fail++;
            $display("FAIL %s actual mode=%0d en=%0b sel=%0b err=%0b mult=%0d ratio=%0d expected mode=%0d en=%0b sel=%0b err=%0b mult=%0d ratio=%0d",
                     e.tag, mode, pll_en, clk_sel, err_flag, pll_mult, clk_ratio,
                     e.md, e.en, e.sel, e.err, e.mult, e.ratio);
         end
      end
   end

   task automatic exp_state(input string tag, input logic [1:0] md, input logic en,
                            input logic sel, input logic [MW-1:0] mult,
                            input logic [MW-1:0] ratio, input logic err);
      exp_t e;
      e.tag = tag; e.is_rd = 1'b0; e.rd = '0; e.md = md; e.en = en; e.sel = sel;
      e.mult = mult; e.ratio = ratio; e.err = err;
      q.push_back(e);
   endtask

   task automatic exp_read(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] v);
      exp_t e;
      addr = a;
      e.tag = tag; e.is_rd = 1'b1; e.rd = v; e.md = '0; e.en = 1'b0; e.sel = 1'b0;
      e.mult = '0; e.ratio = '0; e.err = 1'b0;
      q.push_back(e);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic cycles(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      // R1 reset state
      exp_state("R1 reset", 2'd1, 1, 0, 0, 1, 0);
      exp_read("R1 lock count reset", 2'd2, 16'(RL));
      cycles(1);

      // R2 divide bit in bypass
      wr(2'd1, 16'h0001);
      exp_state("R2 bypass undivided", 2'd1, 1, 0, 0, 2, 0);
      exp_read("R10 ctrl readback", 2'd1, 16'h0001);
      wr(2'd2, 16'(L));
      exp_read("R10 lock readback", 2'd2, 16'(L));

      // R3 counted lock
      wr(2'd0, 16'd6);
      exp_state("R3 write enters bypass", 2'd1, 1, 0, 6, 2, 0);
      exp_read("R10 stat pending", 2'd3, 16'b0101);
      cycles(L);
      exp_state("R3 not yet locked at L", 2'd1, 1, 0, 6, 2, 0);
      cycles(1);
      exp_state("R3 locked at L+1", 2'd2, 1, 1, 6, 6, 0);
      exp_read("R10 mult readback", 2'd0, 16'd6);

      // R3 write from PLL mode, R5 restart
      wr(2'd0, 16'd3);
      exp_state("R3 PLL to bypass on write", 2'd1, 1, 0, 3, 2, 0);
      cycles(1);
      wr(2'd0, 16'd4);
      exp_state("R5 rewrite bypass", 2'd1, 1, 0, 4, 2, 0);
      cycles(L);
      exp_state("R5 restart not yet locked", 2'd1, 1, 0, 4, 2, 0);
      cycles(1);
      exp_state("R5 locked from last write", 2'd2, 1, 1, 4, 4, 0);

      // R6 zero write and cancel
      wr(2'd0, 16'd0);
      exp_state("R6 zero returns bypass", 2'd1, 1, 0, 0, 2, 0);
      wr(2'd0, 16'd7);
      cycles(1);
      wr(2'd0, 16'd0);
      cycles(2 * L + 4);
      exp_state("R6 cancelled wait stays bypass", 2'd1, 1, 0, 0, 2, 0);

      // R4 external lock
      wr(2'd1, 16'h0005);
      wr(2'd0, 16'd5);
      cycles(2 * L + 4);
      exp_state("R4 waits for lock_in", 2'd1, 1, 0, 5, 2, 0);
      lock_in = 1'b1;
      cycles(1);
      exp_state("R4 switch on lock_in", 2'd2, 1, 1, 5, 5, 0);
      wr(2'd0, 16'd2);
      exp_state("R4 write edge ignores lock_in", 2'd1, 1, 0, 2, 2, 0);
      cycles(1);
      exp_state("R4 lock on next edge", 2'd2, 1, 1, 2, 2, 0);
      lock_in = 1'b0;

      // R8 illegal off request
      wr(2'd1, 16'h0003);
      exp_state("R8 off refused", 2'd2, 1, 1, 2, 2, 1);
      exp_read("R10 stat error", 2'd3, 16'b1010);
      cycles(3);
      exp_state("R8 error sticky", 2'd2, 1, 1, 2, 2, 1);
      wr(2'd3, 16'h0002);
      exp_state("R8 error cleared", 2'd2, 1, 1, 2, 2, 0);

      // R7 off mode and R2 in off
      wr(2'd0, 16'd0);
      wr(2'd1, 16'h0002);
      exp_state("R7 off entered", 2'd0, 0, 0, 0, 1, 0);
      exp_read("R10 ctrl off bit", 2'd1, 16'h0002);
      wr(2'd1, 16'h0003);
      exp_state("R2 off undivided", 2'd0, 0, 0, 0, 2, 0);

      // R9 multiplier write while off
      wr(2'd0, 16'd9);
      exp_state("R9 mult ignored while off", 2'd0, 0, 0, 0, 2, 1);
      cycles(L + 3);
      exp_state("R9 still off", 2'd0, 0, 0, 0, 2, 1);
      wr(2'd3, 16'h0002);

      // R7 leave off
      wr(2'd1, 16'h0001);
      exp_state("R7 back to bypass", 2'd1, 1, 0, 0, 2, 0);

      // R4 lock_in with nothing pending
      wr(2'd1, 16'h0005);
      lock_in = 1'b1;
      cycles(4);
      exp_state("R4 lock_in ignored when idle", 2'd1, 1, 0, 0, 2, 0);
      lock_in = 1'b0;
      cycles(2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule